// File: doc/BRIEF.md
# Byte-Wide Auxiliary SPI Master with Chip-Select Hold

This block is a small SPI master that a processor drives through two registers: a control register and a data register. A write to the data register, made while the block is enabled and set to SPI mode, sends one byte out MSB first in SPI mode 0. It also takes in one byte from the slave. While the exchange runs, a busy flag is set. When the exchange ends, the received byte replaces the data register contents, and a one-cycle completion pulse is issued. An optional interrupt pulse comes out alongside it.

The length of one exchange comes from a fixed base rate. The base rate is 2^BASE_LOG2, and it is shifted right by (19 - baud) bits. Baud code 0 is therefore the shortest exchange. Chip select is asserted for every byte. After the byte it is released, unless the hold bit was set. With hold set, a multi-byte slave command can run under one continuous select. A later control write in SPI mode, made while hold is clear, ends that held select.

Top module: `aux_spi_master`

## Requirements
- R1: After reset, busy, done and irq are 0, sclk is 0, cs_n is 1, mosi is 1, and data_rdata and ctrl_rdata are 0.
- R2: A data write starts an exchange only when control bit 0 (enable) and control bit 1 (SPI mode) are both 1. Any other data write is ignored: busy stays 0 and data_rdata keeps its value.
- R3: busy rises in the cycle after the starting data write. It stays high for exactly 2^(BASE_LOG2-19+baud) cycles, where baud is control bits [3:2]. With the default BASE_LOG2 = 24, this is 32, 64, 128 and 256 cycles.
- R4: In the cycle busy falls, data_rdata becomes the 8 bits sampled from miso at the sclk rising edges, first sample in bit 7. With miso held high, it reads 0xFF.
- R5: done is a single-cycle pulse in the cycle busy falls. irq equals done while control bit 5 (interrupt enable) is 1, and stays 0 otherwise.
- R6: sclk is low when idle. During an exchange it gives 8 pulses, each half-period being one sixteenth of the exchange length. mosi presents the written byte MSB first and is valid at each rising edge.
- R7: cs_n is 0 while busy. After the exchange, cs_n returns to 1 unless control bit 4 (hold) was 1 at completion, in which case it stays 0.
- R8: A control write with bit 1 set, made while the previously stored hold bit is 0, releases a held cs_n to 1. If the stored hold bit was 1, the write leaves cs_n as it was. In both cases the new hold value is then stored.
- R9: A starting data write issued while busy restarts the exchange: a full exchange length is counted from that write, and the new byte is sent.
- R10: ctrl_rdata reads back {busy, 0, irq enable, hold, baud[1:0], SPI mode, enable} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write value |
| ctrl_rdata | output | 8 | Control readback with busy in bit 7 |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Byte to transmit |
| data_rdata | output | 8 | Last received byte |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion pulse gated by interrupt enable |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The exchange is run at three baud codes, which tells apart the shift amounts behind the exchange length and the sclk half-period. The slave byte and the transmitted byte are chosen as asymmetric patterns such as 0xA5 and 0x3C, so that a reversed bit order or an off-by-one sample point shows up. A constantly high miso confirms the 0xFF idle read. Data writes with only enable, or only SPI mode, set separate a correct start condition from a single-bit one. A sequence of hold, clear-after-hold and a second clear separates the release rule, which depends on the old hold value, from one that looks at the new value. A mid-exchange rewrite checks that the timing restarts rather than continuing.

// File: rtl/aux_spi_master.sv
module aux_spi_master #(
  parameter int BASE_LOG2 = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  input  logic       data_we,
  input  logic [7:0] data_wdata,
  output logic [7:0] data_rdata,
  output logic       busy,
  output logic       done,
  output logic       irq,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       cs_n
);
  localparam int MIN_SH = BASE_LOG2 - 19;
  localparam int CW     = MIN_SH + 4;

  logic          en, mode, hold, irq_en, held;
  logic [1:0]    baud, baud_run;
  logic [CW-1:0] cnt, last, hmask;
  logic [CW-1:0] phase;
  logic [4:0]    sh;
  logic [7:0]    tx, rx, data_q;
  logic          start, sample_now;

  assign sh         = 5'(MIN_SH - 4) + {3'b000, baud_run};
  assign last       = (CW'(1) << (5'(MIN_SH) + {3'b000, baud_run})) - CW'(1);
  assign hmask      = (CW'(1) << sh) - CW'(1);
  assign phase      = cnt >> sh;
  assign start      = data_we & en & mode;
  assign sample_now = busy & ~phase[0] & ((cnt & hmask) == hmask);

  assign sclk       = busy & phase[0];
  assign mosi       = busy ? tx[3'd7 - phase[3:1]] : 1'b1;
  assign cs_n       = ~(busy | held);
  assign irq        = done & irq_en;
  assign data_rdata = data_q;
  assign ctrl_rdata = {busy, 1'b0, irq_en, hold, baud, mode, en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; mode <= 1'b0; hold <= 1'b0; irq_en <= 1'b0;
      baud <= 2'd0; baud_run <= 2'd0; held <= 1'b0;
      busy <= 1'b0; done <= 1'b0; cnt <= '0;
      tx <= 8'd0; rx <= 8'd0; data_q <= 8'd0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (sample_now) rx <= {rx[6:0], miso};
        if (cnt == last) begin
          busy   <= 1'b0;
          data_q <= rx;
          done   <= 1'b1;
          held   <= hold;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (ctrl_we) begin
        if (ctrl_wdata[1] && !hold) held <= 1'b0;
        en     <= ctrl_wdata[0];
        mode   <= ctrl_wdata[1];
        baud   <= ctrl_wdata[3:2];
        hold   <= ctrl_wdata[4];
        irq_en <= ctrl_wdata[5];
      end
      if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        tx       <= data_wdata;
        baud_run <= baud;
      end
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);
  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R5
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !(en && mode) && !busy) |=> (!busy && $stable(data_rdata)));
endmodule

// File: tb/tb_aux_spi_master.sv
module tb_aux_spi_master;
  localparam int BASE_LOG2 = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, data_we = 1'b0, miso = 1'b1;
  logic [7:0] ctrl_wdata = 8'd0, data_wdata = 8'd0;
  logic [7:0] ctrl_rdata, data_rdata;
  logic busy, done, irq, sclk, mosi, cs_n;

  always #2.5 clk = ~clk;

  aux_spi_master #(.BASE_LOG2(BASE_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .busy(busy), .done(done), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] sbyte = 8'hFF;

  // behavioural reference
  bit m_en, m_mode, m_hold, m_irqen, m_held, m_busy, m_done;
  int m_baud, m_len, m_cnt;
  logic [7:0] m_tx, m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_hold = 0; m_irqen = 0; m_held = 0;
      m_busy = 0; m_done = 0; m_baud = 0; m_len = 32; m_cnt = 0;
      m_tx = 0; m_data = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == m_len - 1) begin
          m_busy = 0; m_data = sbyte; m_done = 1; m_held = m_hold;
        end else m_cnt++;
      end
      if (ctrl_we) begin
        if (ctrl_wdata[1] && !m_hold) m_held = 0;
        m_en = ctrl_wdata[0]; m_mode = ctrl_wdata[1];
        m_baud = int'(ctrl_wdata[3:2]); m_hold = ctrl_wdata[4];
        m_irqen = ctrl_wdata[5];
      end
      if (data_we && m_en && m_mode) begin
        m_busy = 1; m_cnt = 0; m_tx = data_wdata;
        m_len = 1 << (BASE_LOG2 - 19 + m_baud);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic prev_sclk = 1'b0;
  logic [7:0] cap;
  int pulses;

  always @(negedge clk) begin
    int ph, bi;
    logic [13:0] act, exp;
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
    end
    if (rst_n) begin
      ph = m_busy ? m_cnt / (m_len / 16) : 0;
      bi = ph / 2;
      act = {busy, done, sclk, mosi, cs_n, irq, data_rdata};
      exp = {m_busy, m_done, m_busy && (ph % 2 == 1),
             m_busy ? m_tx[7 - bi] : 1'b1, !(m_busy || m_held),
             m_done && m_irqen, m_data};
      chk(act == exp, "R3 R4 R5 R6 R7 cycle compare", int'(act), int'(exp));
      if (sclk && !prev_sclk) begin cap = {cap[6:0], mosi}; pulses++; end
      prev_sclk = sclk;
      miso <= m_busy ? sbyte[7 - bi] : 1'b1;
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wdata = v; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic run_byte(input logic [7:0] txb, input logic [7:0] sb, input int len);
    int n;
    sbyte = sb; cap = 8'd0; pulses = 0;
    @(negedge clk); data_wdata = txb; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == len, "R3 exchange length", n, len);
    chk(done == 1'b1, "R5 done at busy fall", int'(done), 1);
    chk(data_rdata == sb, "R4 received byte", int'(data_rdata), int'(sb));
    chk(cap == txb, "R6 mosi MSB first", int'(cap), int'(txb));
    chk(pulses == 8, "R6 sclk pulse count", pulses, 8);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, irq, sclk, cs_n, mosi} == 6'b000011, "R1 reset outputs",
        int'({busy, done, irq, sclk, cs_n, mosi}), 3);
    chk(data_rdata == 8'd0 && ctrl_rdata == 8'd0, "R1 reset registers",
        int'({data_rdata, ctrl_rdata}), 0);

    wr_ctrl(8'h01);
    @(negedge clk); data_wdata = 8'h77; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    chk(busy == 1'b0 && data_rdata == 8'd0, "R2 enable only ignored",
        int'({busy, data_rdata}), 0);
    wr_ctrl(8'h02);
    @(negedge clk); data_wdata = 8'h77; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    chk(busy == 1'b0 && data_rdata == 8'd0, "R2 mode only ignored",
        int'({busy, data_rdata}), 0);

    wr_ctrl(8'h03);
    run_byte(8'hA5, 8'h3C, 32);
    chk(cs_n == 1'b1, "R7 release without hold", int'(cs_n), 1);
    wr_ctrl(8'h0B);
    run_byte(8'h5A, 8'hFF, 128);
    wr_ctrl(8'h0F);
    chk(ctrl_rdata == 8'h0F, "R10 ctrl readback", int'(ctrl_rdata), 8'h0F);
    run_byte(8'h81, 8'hC3, 256);

    wr_ctrl(8'h13);
    run_byte(8'h9F, 8'h12, 32);
    chk(cs_n == 1'b0, "R7 hold keeps select", int'(cs_n), 0);
    run_byte(8'h00, 8'hE7, 32);
    chk(cs_n == 1'b0, "R7 hold second byte", int'(cs_n), 0);
    wr_ctrl(8'h03);
    chk(cs_n == 1'b0, "R8 old hold set keeps select", int'(cs_n), 0);
    wr_ctrl(8'h03);
    chk(cs_n == 1'b1, "R8 old hold clear releases", int'(cs_n), 1);

    wr_ctrl(8'h23);
    sbyte = 8'h66;
    @(negedge clk); data_wdata = 8'h44; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    while (busy) @(negedge clk);
    chk(irq == 1'b1 && done == 1'b1, "R5 irq with done", int'({irq, done}), 3);

    wr_ctrl(8'h03);
    sbyte = 8'hB1;
    @(negedge clk); data_wdata = 8'h11; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    repeat (9) @(negedge clk);
    cap = 8'd0; pulses = 0;
    data_wdata = 8'hD2; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == 32, "R9 restart length", n, 32);
    chk(cap == 8'hD2, "R9 restart byte", int'(cap), 8'hD2);
    chk(data_rdata == 8'hB1, "R9 restart received", int'(data_rdata), 8'hB1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule